// File: doc/BRIEF.md
# Receive Descriptor Ring Free Tracker

This block keeps a running count of the free receive buffer descriptors in several independent circular rings. Software sets each ring's length and free-descriptor threshold. It also reports the index of the last descriptor it handed back. Hardware signals each descriptor it consumes and each descriptor it writes back as occupied. For every ring the block reports the number of descriptors that are guaranteed free, an empty flag, a full flag, a sticky busy-error flag, and a pause request for the flow-control logic.

Pointers are descriptor indices from 0 to length−1. When the two pointers are equal, the ring could be completely free or almost exhausted. A small per-ring state records which agent made the pointers equal, and that state decides between the two cases. A separate write-back step moves the ring from "one descriptor left" to "full". Every output is registered. A change on the inputs before a clock edge appears on the outputs just after that edge.

Top module: `rx_ring_free_tracker`

## Requirements
- R1: A ring init pulse sets both pointers of that ring to index 0. The ring then reports empty=1, full=0 and free count = ring length. Init takes priority over every other input of that ring in the same cycle.
- R2: When the freed index is greater than the consume index, the free count is freed − consume.
- R3: When the freed index is less than the consume index, the free count is length + freed − consume. The consume index wraps from length−1 to 0.
- R4: A software freed-index write equal to the current consume index marks the ring empty, with free count = length. This also applies when the ring was full.
- R5: A consume advance that makes the consume index equal to the freed index leaves the ring in a one-left state: free count 1, empty=0, full=0.
- R6: A write-back pulse in the one-left state makes the ring full, with free count 0 and full=1. A write-back in any other state has no effect on the outputs.
- R7: A consume advance in the one-left or full state is refused and the free count is unchanged. The refusal sets busy_err, which stays at 1 until an error-clear pulse. If a refusal and a clear happen in the same cycle, the flag is set.
- R8: pause is 1 exactly when the ring is enabled and its next free count is at most that ring's own threshold. A disabled ring never requests pause.
- R9: If a software freed-index write and a consume advance happen in the same cycle, the write is applied first and the advance is evaluated against the new freed index.
- R10: While reset is high, all outputs are 0. On the first edge after reset, each ring reports empty with free count = length.
- R11: Rings are independent. Inputs for one ring never change the outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len | input | NUM_RINGS*CNT_W | Ring length per ring (1 to 2^IDX_W) |
| cfg_thresh | input | NUM_RINGS*CNT_W | Free-descriptor pause threshold per ring |
| cfg_en | input | NUM_RINGS | Ring enable; gates pause |
| sw_init | input | NUM_RINGS | Ring base reload pulse |
| sw_free_wr | input | NUM_RINGS | Software freed-index write strobe |
| sw_free_idx | input | NUM_RINGS*IDX_W | Freed index written by software |
| sw_err_clr | input | NUM_RINGS | Clear busy-error pulse |
| hw_adv | input | NUM_RINGS | Hardware consume-advance pulse |
| hw_wb | input | NUM_RINGS | Hardware descriptor write-back pulse |
| free_cnt | output | NUM_RINGS*CNT_W | Guaranteed free descriptors per ring |
| empty | output | NUM_RINGS | Ring fully free |
| full | output | NUM_RINGS | Ring has no free descriptor |
| pause | output | NUM_RINGS | Flow-control request |
| busy_err | output | NUM_RINGS | Sticky refused-consume flag |

## Verification
The bench drives the pointers into equality by each route. A design that ignored the collision state would report 0 or the full length where the ring actually has one descriptor left. It also frees the last index while the ring is full, the backlog case, and a design that compared the raw pointers would not report empty there. A simultaneous write and advance is chosen so that the reverse ordering would give empty instead of one-left. The bench also wraps the consume index, tests the pause threshold at equality, and checks that a write-back outside the one-left state has no effect.

// File: rtl/rft_pkg.sv
package rft_pkg;
  typedef enum logic [1:0] {
    RS_EMPTY = 2'd0,
    RS_OPEN  = 2'd1,
    RS_LAST  = 2'd2,
    RS_FULL  = 2'd3
  } ring_state_e;
endpackage

// File: rtl/rft_ring_step.sv
module rft_ring_step
  import rft_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic [CNT_W-1:0] len,
  input  logic [IDX_W-1:0] cons,
  input  logic [IDX_W-1:0] freed,
  input  ring_state_e      st,
  input  logic             init,
  input  logic             sw_wr,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic             adv,
  input  logic             wb,
  output logic [IDX_W-1:0] cons_n,
  output logic [IDX_W-1:0] freed_n,
  output ring_state_e      st_n,
  output logic             refuse
);
  logic [IDX_W-1:0] cons_inc;
  logic             at_end;

  assign at_end   = ({1'b0, cons} == len - CNT_W'(1));
  assign cons_inc = at_end ? '0 : cons + IDX_W'(1);

  always_comb begin
    cons_n  = cons;
    freed_n = freed;
    st_n    = st;
    refuse  = 1'b0;
    if (init) begin
      cons_n  = '0;
      freed_n = '0;
      st_n    = RS_EMPTY;
    end else begin
      // software write first
      if (sw_wr) begin
        freed_n = sw_idx;
        st_n    = (sw_idx == cons) ? RS_EMPTY : RS_OPEN;
      end else if (wb && st == RS_LAST) begin
        st_n = RS_FULL;
      end
      // then hardware advance against the updated state
      if (adv) begin
        if (st_n == RS_EMPTY || st_n == RS_OPEN) begin
          cons_n = cons_inc;
          st_n   = (cons_inc == freed_n) ? RS_LAST : RS_OPEN;
        end else begin
          refuse = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rft_free_count.sv
module rft_free_count
  import rft_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic [CNT_W-1:0] len,
  input  logic [IDX_W-1:0] cons,
  input  logic [IDX_W-1:0] freed,
  input  ring_state_e      st,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] c_ext, f_ext;
  assign c_ext = {1'b0, cons};
  assign f_ext = {1'b0, freed};

  always_comb begin
    unique case (st)
      RS_EMPTY: cnt = len;
      RS_LAST:  cnt = CNT_W'(1);
      RS_FULL:  cnt = '0;
      default:  cnt = (f_ext > c_ext) ? (f_ext - c_ext) : (len + f_ext - c_ext);
    endcase
  end
endmodule

// File: rtl/rft_ring.sv
module rft_ring
  import rft_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] len,
  input  logic [CNT_W-1:0] thresh,
  input  logic             en,
  input  logic             init,
  input  logic             sw_wr,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic             err_clr,
  input  logic             adv,
  input  logic             wb,
  output logic [CNT_W-1:0] free_cnt,
  output logic             empty,
  output logic             full,
  output logic             pause,
  output logic             busy_err
);
  logic [IDX_W-1:0] cons_q, freed_q, cons_n, freed_n;
  ring_state_e      st_q, st_n;
  logic             refuse;
  logic [CNT_W-1:0] cnt_n;

  rft_ring_step #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_step (
    .len(len), .cons(cons_q), .freed(freed_q), .st(st_q),
    .init(init), .sw_wr(sw_wr), .sw_idx(sw_idx), .adv(adv), .wb(wb),
    .cons_n(cons_n), .freed_n(freed_n), .st_n(st_n), .refuse(refuse)
  );

  rft_free_count #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_cnt (
    .len(len), .cons(cons_n), .freed(freed_n), .st(st_n), .cnt(cnt_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cons_q   <= '0;
      freed_q  <= '0;
      st_q     <= RS_EMPTY;
      free_cnt <= '0;
      empty    <= 1'b0;
      full     <= 1'b0;
      pause    <= 1'b0;
      busy_err <= 1'b0;
    end else begin
      cons_q   <= cons_n;
      freed_q  <= freed_n;
      st_q     <= st_n;
      free_cnt <= cnt_n;
      empty    <= (st_n == RS_EMPTY);
      full     <= (st_n == RS_FULL);
      pause    <= en && (cnt_n <= thresh);
      busy_err <= (busy_err && !err_clr) || refuse;
    end
  end
endmodule

// File: rtl/rx_ring_free_tracker.sv
module rx_ring_free_tracker #(
  parameter int NUM_RINGS = 2,
  parameter int IDX_W     = 4,
  localparam int CNT_W    = IDX_W + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_RINGS*CNT_W-1:0] cfg_len,
  input  logic [NUM_RINGS*CNT_W-1:0] cfg_thresh,
  input  logic [NUM_RINGS-1:0]       cfg_en,
  input  logic [NUM_RINGS-1:0]       sw_init,
  input  logic [NUM_RINGS-1:0]       sw_free_wr,
  input  logic [NUM_RINGS*IDX_W-1:0] sw_free_idx,
  input  logic [NUM_RINGS-1:0]       sw_err_clr,
  input  logic [NUM_RINGS-1:0]       hw_adv,
  input  logic [NUM_RINGS-1:0]       hw_wb,
  output logic [NUM_RINGS*CNT_W-1:0] free_cnt,
  output logic [NUM_RINGS-1:0]       empty,
  output logic [NUM_RINGS-1:0]       full,
  output logic [NUM_RINGS-1:0]       pause,
  output logic [NUM_RINGS-1:0]       busy_err
);
  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    rft_ring #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_ring (
      .clk      (clk),
      .rst      (rst),
      .len      (cfg_len[g*CNT_W +: CNT_W]),
      .thresh   (cfg_thresh[g*CNT_W +: CNT_W]),
      .en       (cfg_en[g]),
      .init     (sw_init[g]),
      .sw_wr    (sw_free_wr[g]),
      .sw_idx   (sw_free_idx[g*IDX_W +: IDX_W]),
      .err_clr  (sw_err_clr[g]),
      .adv      (hw_adv[g]),
      .wb       (hw_wb[g]),
      .free_cnt (free_cnt[g*CNT_W +: CNT_W]),
      .empty    (empty[g]),
      .full     (full[g]),
      .pause    (pause[g]),
      .busy_err (busy_err[g])
    );
  end
endmodule

// File: rtl/rft_checker.sv
module rft_checker #(
  parameter int NUM_RINGS = 2,
  parameter int IDX_W     = 4,
  localparam int CNT_W    = IDX_W + 1
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_RINGS*CNT_W-1:0] cfg_len,
  input logic [NUM_RINGS-1:0]       cfg_en,
  input logic [NUM_RINGS-1:0]       sw_init,
  input logic [NUM_RINGS-1:0]       hw_adv,
  input logic [NUM_RINGS*CNT_W-1:0] free_cnt,
  input logic [NUM_RINGS-1:0]       empty,
  input logic [NUM_RINGS-1:0]       full,
  input logic [NUM_RINGS-1:0]       pause,
  input logic [NUM_RINGS-1:0]       busy_err
);
  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_chk
    assert_init_empty_R1: assert property (@(posedge clk) disable iff (rst)
      sw_init[g] |=> empty[g]);
    assert_empty_all_R1: assert property (@(posedge clk) disable iff (rst)
      (empty[g] && $stable(cfg_len[g*CNT_W +: CNT_W]))
        |-> free_cnt[g*CNT_W +: CNT_W] == cfg_len[g*CNT_W +: CNT_W]);
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
      $stable(cfg_len[g*CNT_W +: CNT_W])
        |-> free_cnt[g*CNT_W +: CNT_W] <= cfg_len[g*CNT_W +: CNT_W]);
    assert_full_zero_R6: assert property (@(posedge clk) disable iff (rst)
      full[g] |-> free_cnt[g*CNT_W +: CNT_W] == '0);
    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
      !(full[g] && empty[g]));
    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(busy_err[g]) |-> $past(hw_adv[g]));
    assert_pause_gated_R8: assert property (@(posedge clk) disable iff (rst)
      !cfg_en[g] |=> !pause[g]);
  end
endmodule

bind rx_ring_free_tracker rft_checker #(.NUM_RINGS(NUM_RINGS), .IDX_W(IDX_W)) u_rft_chk (
  .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_en(cfg_en), .sw_init(sw_init),
  .hw_adv(hw_adv), .free_cnt(free_cnt), .empty(empty), .full(full),
  .pause(pause), .busy_err(busy_err)
);

// File: tb/tb_rx_ring_free_tracker.sv
`timescale 1ns/1ps
module tb_rx_ring_free_tracker;
  localparam int N     = 2;
  localparam int IDX_W = 4;
  localparam int CNT_W = IDX_W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*CNT_W-1:0] cfg_len, cfg_thresh, free_cnt;
  logic [N-1:0] cfg_en, sw_init, sw_free_wr, sw_err_clr, hw_adv, hw_wb;
  logic [N*IDX_W-1:0] sw_free_idx;
  logic [N-1:0] empty, full, pause, busy_err;

  always #2 clk = ~clk;

  rx_ring_free_tracker #(.NUM_RINGS(N), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .cfg_len(cfg_len), .cfg_thresh(cfg_thresh), .cfg_en(cfg_en),
    .sw_init(sw_init), .sw_free_wr(sw_free_wr), .sw_free_idx(sw_free_idx),
    .sw_err_clr(sw_err_clr), .hw_adv(hw_adv), .hw_wb(hw_wb),
    .free_cnt(free_cnt), .empty(empty), .full(full), .pause(pause), .busy_err(busy_err)
  );

  typedef struct {
    int    ring;
    int    cnt;
    bit    e, f, p, err;
    string tag;
  } exp_t;

  exp_t sbq[$];
  exp_t cur;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic tick();
    @(posedge clk); #1;
    sw_init = '0; sw_free_wr = '0; sw_err_clr = '0; hw_adv = '0; hw_wb = '0;
  endtask

  task automatic expect_ring(int r, int c, bit e, bit f, bit p, bit er, string tag);
    exp_t it;
    it.ring = r; it.cnt = c; it.e = e; it.f = f; it.p = p; it.err = er; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic free_wr(int r, int idx);
    sw_free_wr[r] = 1'b1;
    sw_free_idx[r*IDX_W +: IDX_W] = IDX_W'(idx);
  endtask

  // monitor: compares after the edge, away from it
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      cur = sbq.pop_front();
      checks++;
      if (int'(free_cnt[cur.ring*CNT_W +: CNT_W]) != cur.cnt || empty[cur.ring] != cur.e ||
          full[cur.ring] != cur.f || pause[cur.ring] != cur.p || busy_err[cur.ring] != cur.err) begin
        errors++;
        $display("FAIL %s ring%0d: got cnt=%0d e=%0b f=%0b p=%0b err=%0b exp cnt=%0d e=%0b f=%0b p=%0b err=%0b",
                 cur.tag, cur.ring, free_cnt[cur.ring*CNT_W +: CNT_W], empty[cur.ring],
                 full[cur.ring], pause[cur.ring], busy_err[cur.ring],
                 cur.cnt, cur.e, cur.f, cur.p, cur.err);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_len = '0; cfg_thresh = '0;
    cfg_len[0 +: CNT_W] = 5'd8;     cfg_thresh[0 +: CNT_W] = 5'd2;
    cfg_len[CNT_W +: CNT_W] = 5'd5; cfg_thresh[CNT_W +: CNT_W] = 5'd1;
    cfg_en = 2'b11;
    sw_init = '0; sw_free_wr = '0; sw_free_idx = '0; sw_err_clr = '0; hw_adv = '0; hw_wb = '0;

    tick(); expect_ring(0, 0, 0, 0, 0, 0, "R10 reset");
    rst = 1'b0;
    tick(); expect_ring(0, 8, 1, 0, 0, 0, "R10 post-reset");
            expect_ring(1, 5, 1, 0, 0, 0, "R10 post-reset");

    free_wr(0, 5); tick(); expect_ring(0, 5, 0, 0, 0, 0, "R2 freed ahead");
    hw_adv[0] = 1; tick(); expect_ring(0, 4, 0, 0, 0, 0, "R2 adv");
    hw_adv[0] = 1; tick(); expect_ring(0, 3, 0, 0, 0, 0, "R2 adv");
    hw_adv[0] = 1; tick(); expect_ring(0, 2, 0, 0, 1, 0, "R8 at threshold");
    hw_adv[0] = 1; tick(); expect_ring(0, 1, 0, 0, 1, 0, "R8 below threshold");
    hw_adv[0] = 1; tick(); expect_ring(0, 1, 0, 0, 1, 0, "R5 one left");
    hw_adv[0] = 1; tick(); expect_ring(0, 1, 0, 0, 1, 1, "R7 refused in one-left");
    hw_wb[0] = 1;  tick(); expect_ring(0, 0, 0, 1, 1, 1, "R6 write-back to full");
    hw_adv[0] = 1; tick(); expect_ring(0, 0, 0, 1, 1, 1, "R7 refused when full");
    tick();               expect_ring(0, 0, 0, 1, 1, 1, "R7 error sticky");
    sw_err_clr[0] = 1; tick(); expect_ring(0, 0, 0, 1, 1, 0, "R7 error cleared");
    free_wr(0, 5); tick(); expect_ring(0, 8, 1, 0, 0, 0, "R4 backlog free equals consume");
    hw_wb[0] = 1;  tick(); expect_ring(0, 8, 1, 0, 0, 0, "R6 write-back ignored");
    hw_adv[0] = 1; tick(); expect_ring(0, 7, 0, 0, 0, 0, "R3 freed behind");
    hw_adv[0] = 1; tick(); expect_ring(0, 6, 0, 0, 0, 0, "R3 freed behind");
    hw_adv[0] = 1; tick(); expect_ring(0, 5, 0, 0, 0, 0, "R3 wrap to 0");
    free_wr(0, 3); tick(); expect_ring(0, 3, 0, 0, 0, 0, "R2 after wrap");
    hw_adv[0] = 1; tick(); expect_ring(0, 2, 0, 0, 1, 0, "R2 adv");
    hw_adv[0] = 1; tick(); expect_ring(0, 1, 0, 0, 1, 0, "R5 one left via adv");
    free_wr(0, 6); hw_adv[0] = 1; tick(); expect_ring(0, 3, 0, 0, 0, 0, "R9 write and adv");
    free_wr(0, 4); hw_adv[0] = 1; tick(); expect_ring(0, 1, 0, 0, 1, 0, "R9 write first then collide");
    cfg_en[0] = 0; tick(); expect_ring(0, 1, 0, 0, 0, 0, "R8 disabled ring");
    cfg_en[0] = 1;
    free_wr(1, 2); tick(); expect_ring(1, 2, 0, 0, 0, 0, "R11 ring1 own threshold");
                           expect_ring(0, 1, 0, 0, 1, 0, "R11 ring0 untouched");
    hw_adv[1] = 1; tick(); expect_ring(1, 1, 0, 0, 1, 0, "R5 ring1 one left");
                           expect_ring(0, 1, 0, 0, 1, 0, "R11 ring0 untouched");
    cfg_thresh[0 +: CNT_W] = 5'd7;
    sw_init[0] = 1; hw_adv[0] = 1; tick(); expect_ring(0, 8, 1, 0, 0, 0, "R1 init overrides adv");
    hw_adv[0] = 1; tick(); expect_ring(0, 7, 0, 0, 1, 0, "R3 pause at raised threshold");
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule